// File: doc/BRIEF.md
# ISDN Basic-Rate Frame Interface

This block connects a chip's internal serial channel ports to a basic-rate ISDN line bus. The bus carries a bit clock and an 8 kHz frame sync. Each frame holds eight B1 bits, eight B2 bits and two D bits. On receive, the block samples the line, files each bit under its channel and publishes the whole B1, B2 and D content of a frame at once. On transmit, it builds the outgoing frame from the serial ports and from a D-channel sender. Two frame layouts are supported, picked by a format input that is taken at each sync. They differ only in the order of the channels.

A routing table holds one entry for each of the twenty active bit positions. Each entry sends that position to one of the serial ports, to a strobe output for external logic, or to nowhere. Software edits a shadow copy of the table, and the copy becomes live at a frame boundary. The D-channel sender follows a request/grant handshake with the line device. While D bits are pending, it raises a request. It looks at the grant only in the sync cycle, and it fills the frame's two D positions only if the grant was present there. The caller supplies whole D bits, with any flag, stuffing or check sequence already built. The first D bit of a granted frame is therefore the opening zero of the caller's flag.

Top module: `isdn_idl_frm`

## Requirements
- R1: After reset, l1_txd is 1, l1_req, l1_strobe, d_tx_taken and rx_frame_vld are 0, and port_rx_vld and port_tx_tap are all zero.
- R2: The rising edge that sees l1_sync high starts a frame. The bit period after that edge is position 0, and each later rising edge advances one position. Transmit bits change on the rising edge, and l1_rxd is sampled on the falling edge inside each bit period.
- R3: With fmt10_sel high at sync, the layout is: positions 0..7 B1, 8 D1, 9 spare, 10..17 B2, 18 D2, 19 spare.
- R4: With fmt10_sel low at sync, the layout is: positions 0..7 B1, 8..15 B2, 16 D1, 17 D2, and positions 18 and 19 spare.
- R5: rx_b1 and rx_b2 hold the received B bits with the first bit received in bit 7. rx_d[1] holds D1 and rx_d[0] holds D2. All three are updated at the falling edge of position 19, and rx_frame_vld is high for one bit period from that edge.
- R6: A route code of 2+k sends a position to port k. On transmit, port_tx_tap[k] is high and l1_txd carries port_txd[k]. On receive, port_rx_vld[k] is high for the bit period that starts at the sampling edge, and port_rxd carries the sampled bit.
- R7: l1_txd is 1 at positions with route code 0 or 1, at non-D positions outside 0..19, and between frames. Positions with code 0 or 1 raise no port_rx_vld.
- R8: Route code 1 raises l1_strobe for that position's bit period.
- R9: A table write (rt_wr_en, rt_wr_slot, rt_wr_code) takes effect at the next sync edge. A write issued in the sync cycle itself applies to the frame that sync starts. A write made mid-frame leaves the rest of the current frame unchanged.
- R10: l1_req follows d_tx_valid one edge later. It drops at the edge that ends the D2 position of a granted frame.
- R11: The grant is sampled only at the sync edge. If l1_gnt and d_tx_valid are both high there, D1 carries d_tx_bits[1] and D2 carries d_tx_bits[0], and d_tx_taken is high for the bit period after D2.
- R12: If the grant is low at sync, both D positions send 1, d_tx_taken stays low, and l1_req stays high while d_tx_valid remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line bit clock |
| rst | input | 1 | Synchronous active-high reset |
| l1_sync | input | 1 | Frame sync from the line |
| l1_rxd | input | 1 | Receive line data |
| l1_txd | output | 1 | Transmit line data |
| l1_gnt | input | 1 | D-channel grant from the line device |
| l1_req | output | 1 | D-channel request to the line device |
| l1_strobe | output | 1 | Strobe for positions routed to it |
| fmt10_sel | input | 1 | Frame layout select, taken at sync (1 = ten-bit layout) |
| rt_wr_en | input | 1 | Routing table write enable |
| rt_wr_slot | input | 5 | Bit position to write |
| rt_wr_code | input | 3 | Route code: 0 none, 1 strobe, 2+k port k |
| port_txd | input | 4 | Transmit bit from each serial port |
| port_tx_tap | output | 4 | Port whose bit is on the line now |
| port_rx_vld | output | 4 | Port that owns the bit on port_rxd |
| port_rxd | output | 1 | Received bit for the flagged port |
| d_tx_valid | input | 1 | D bits are pending |
| d_tx_bits | input | 2 | D bits to send (bit 1 goes first) |
| d_tx_taken | output | 1 | The pending D bits were sent |
| rx_b1 | output | 8 | Received B1 byte |
| rx_b2 | output | 8 | Received B2 byte |
| rx_d | output | 2 | Received D bits |
| rx_frame_vld | output | 1 | Frame capture updated |

## Verification
Two pairs of events can land in the same sync cycle. First, a routing table write can arrive in the sync cycle, when the shadow table is copied to the live one. The bench issues such a write and expects the new code to be seen in the frame that sync opens. It also issues a write in the middle of a frame and expects the old code to stay in force until the next sync. Second, a pending D request can meet the grant sample at sync. The bench runs frames with grant present and absent at sync, and then flips the grant right after sync. D-slot bits, d_tx_taken and l1_req must depend only on the value seen at sync.

// File: rtl/isdn_frm_pkg.sv
package isdn_frm_pkg;

    localparam int ACTIVE_SLOTS = 20;
    localparam int SLOT_W       = $clog2(ACTIVE_SLOTS);
    localparam int RC_NONE      = 0;
    localparam int RC_STRB      = 1;
    localparam int RC_PORT0     = 2;

    typedef enum logic [2:0] {
        SK_IDLE,
        SK_B1,
        SK_B2,
        SK_D1,
        SK_D2,
        SK_SPARE
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e kind;
        logic [2:0] bidx;
    } slot_info_t;

    // Map a frame position to its channel for the chosen layout.
    function automatic slot_info_t decode_slot(input logic [15:0] pos, input logic fmt10);
        slot_info_t s;
        logic [15:0] t;
        s.kind = SK_IDLE;
        s.bidx = 3'd0;
        t      = 16'd0;
        if (pos < 16'd8) begin
            s.kind = SK_B1;
            s.bidx = pos[2:0];
        end else if (fmt10) begin
            if (pos == 16'd8) begin
                s.kind = SK_D1;
            end else if (pos >= 16'd10 && pos < 16'd18) begin
                t      = pos - 16'd10;
                s.kind = SK_B2;
                s.bidx = t[2:0];
            end else if (pos == 16'd18) begin
                s.kind = SK_D2;
            end else if (pos < 16'(ACTIVE_SLOTS)) begin
                s.kind = SK_SPARE;
            end
        end else begin
            if (pos < 16'd16) begin
                s.kind = SK_B2;
                s.bidx = pos[2:0];
            end else if (pos == 16'd16) begin
                s.kind = SK_D1;
            end else if (pos == 16'd17) begin
                s.kind = SK_D2;
            end else if (pos < 16'(ACTIVE_SLOTS)) begin
                s.kind = SK_SPARE;
            end
        end
        return s;
    endfunction

    function automatic logic is_dslot(input slot_info_t s);
        return (s.kind == SK_D1) || (s.kind == SK_D2);
    endfunction

endpackage

// File: rtl/frm_timer.sv
module frm_timer
    import isdn_frm_pkg::*;
#(
    parameter int FRAME_LEN = 256,
    localparam int POS_W    = $clog2(FRAME_LEN)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             sync_in,
    input  logic             fmt10_in,
    output logic [POS_W-1:0] pos,
    output logic             in_frame,
    output logic             slot_act,
    output logic             last_slot,
    output slot_info_t       slot_info
);

    logic fmt10_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos      <= '0;
            in_frame <= 1'b0;
            fmt10_q  <= 1'b0;
        end else if (sync_in) begin
            pos      <= '0;
            in_frame <= 1'b1;
            fmt10_q  <= fmt10_in;
        end else if (in_frame) begin
            if (pos == POS_W'(FRAME_LEN - 1)) begin
                in_frame <= 1'b0;
            end else begin
                pos <= pos + 1'b1;
            end
        end
    end

    always_comb begin
        slot_act  = in_frame && (pos < POS_W'(ACTIVE_SLOTS));
        last_slot = in_frame && (pos == POS_W'(ACTIVE_SLOTS - 1));
        slot_info = decode_slot(16'(pos), fmt10_q);
        if (!slot_act) begin
            slot_info.kind = SK_IDLE;
            slot_info.bidx = 3'd0;
        end
    end

    // R2: the edge that sees sync starts a frame at position 0
    a_r2_sync_restarts: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sync_in)) |-> (pos == '0 && in_frame));

    // R2: positions advance by one inside a frame
    a_r2_pos_advances: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(sync_in) && $past(in_frame) && in_frame) |-> (pos == $past(pos) + 1'b1));

endmodule

// File: rtl/frm_route_tab.sv
module frm_route_tab
    import isdn_frm_pkg::*;
#(
    parameter int CODE_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [SLOT_W-1:0] wr_slot,
    input  logic [CODE_W-1:0] wr_code,
    input  logic              commit,
    input  logic [SLOT_W-1:0] rd_slot,
    output logic [CODE_W-1:0] rd_code
);

    logic [CODE_W-1:0] shd [ACTIVE_SLOTS];
    logic [CODE_W-1:0] act [ACTIVE_SLOTS];

    for (genvar i = 0; i < ACTIVE_SLOTS; i++) begin : g_ent
        logic [CODE_W-1:0] nxt;
        assign nxt = (wr_en && wr_slot == SLOT_W'(i)) ? wr_code : shd[i];

        always_ff @(posedge clk) begin
            if (rst) begin
                shd[i] <= CODE_W'(RC_NONE);
                act[i] <= CODE_W'(RC_NONE);
            end else begin
                shd[i] <= nxt;
                if (commit) begin
                    act[i] <= nxt;
                end
            end
        end

        // R9: the live entry changes only at a frame boundary
        a_r9_live_holds: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && !$past(commit)) |-> $stable(act[i]));
    end

    always_comb begin
        rd_code = CODE_W'(RC_NONE);
        for (int i = 0; i < ACTIVE_SLOTS; i++) begin
            if (rd_slot == SLOT_W'(i)) begin
                rd_code = act[i];
            end
        end
    end

endmodule

// File: rtl/frm_dchan.sv
module frm_dchan (
    input  logic       clk,
    input  logic       rst,
    input  logic       sync_in,
    input  logic       gnt,
    input  logic       pend,
    input  logic [1:0] bits_in,
    input  logic       at_d2,
    output logic       cmt,
    output logic [1:0] hold,
    output logic       req,
    output logic       taken
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmt   <= 1'b0;
            hold  <= 2'b11;
            req   <= 1'b0;
            taken <= 1'b0;
        end else begin
            taken <= 1'b0;
            if (sync_in) begin
                cmt  <= gnt && pend;
                hold <= bits_in;
                req  <= pend;
            end else if (cmt && at_d2) begin
                cmt   <= 1'b0;
                taken <= 1'b1;
                req   <= 1'b0;
            end else begin
                req <= pend;
            end
        end
    end

    // R11: a send report needs a frame that was granted
    a_r11_taken_after_commit: assert property (@(posedge clk) disable iff (rst)
        taken |-> $past(cmt));

    // R10: the request is down when the send is reported
    a_r10_req_drops_on_send: assert property (@(posedge clk) disable iff (rst)
        taken |-> !req);

    // R12: no grant at sync means no transmit this frame
    a_r12_no_grant_no_commit: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(sync_in) && !$past(gnt)) |-> !cmt);

endmodule

// File: rtl/frm_rx_capture.sv
module frm_rx_capture
    import isdn_frm_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int CODE_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 rxd,
    input  logic                 slot_act,
    input  logic                 last_slot,
    input  slot_info_t           slot_info,
    input  logic [CODE_W-1:0]    code,
    output logic [NUM_PORTS-1:0] port_rx_vld,
    output logic                 port_rxd,
    output logic [7:0]           rx_b1,
    output logic [7:0]           rx_b2,
    output logic [1:0]           rx_d,
    output logic                 rx_frame_vld
);

    logic [7:0] b1_acc;
    logic [7:0] b2_acc;
    logic [1:0] d_acc;

    always_ff @(negedge clk) begin
        if (rst) begin
            port_rx_vld  <= '0;
            port_rxd     <= 1'b1;
            b1_acc       <= '0;
            b2_acc       <= '0;
            d_acc        <= '0;
            rx_b1        <= '0;
            rx_b2        <= '0;
            rx_d         <= '0;
            rx_frame_vld <= 1'b0;
        end else begin
            port_rx_vld  <= '0;
            rx_frame_vld <= 1'b0;
            if (slot_act) begin
                port_rxd <= rxd;
                for (int k = 0; k < NUM_PORTS; k++) begin
                    port_rx_vld[k] <= (code == CODE_W'(RC_PORT0 + k));
                end
                case (slot_info.kind)
                    SK_B1:   b1_acc[3'd7 - slot_info.bidx] <= rxd;
                    SK_B2:   b2_acc[3'd7 - slot_info.bidx] <= rxd;
                    SK_D1:   d_acc[1] <= rxd;
                    SK_D2:   d_acc[0] <= rxd;
                    default: ;
                endcase
                if (last_slot) begin
                    rx_b1        <= b1_acc;
                    rx_b2        <= b2_acc;
                    rx_d         <= d_acc;
                    rx_frame_vld <= 1'b1;
                end
            end
        end
    end

    // R7: port data only comes from sampled active positions
    a_r7_rx_only_in_window: assert property (@(negedge clk) disable iff (rst)
        (|port_rx_vld) |-> $past(slot_act));

    // R6: a received bit belongs to at most one port
    a_r6_rx_single_owner: assert property (@(negedge clk) disable iff (rst)
        $onehot0(port_rx_vld));

endmodule

// File: rtl/isdn_idl_frm.sv
module isdn_idl_frm
    import isdn_frm_pkg::*;
#(
    parameter int NUM_PORTS = 4,
    parameter int FRAME_LEN = 256,
    localparam int CODE_W   = $clog2(NUM_PORTS + RC_PORT0),
    localparam int POS_W    = $clog2(FRAME_LEN)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 l1_sync,
    input  logic                 l1_rxd,
    output logic                 l1_txd,
    input  logic                 l1_gnt,
    output logic                 l1_req,
    output logic                 l1_strobe,
    input  logic                 fmt10_sel,
    input  logic                 rt_wr_en,
    input  logic [SLOT_W-1:0]    rt_wr_slot,
    input  logic [CODE_W-1:0]    rt_wr_code,
    input  logic [NUM_PORTS-1:0] port_txd,
    output logic [NUM_PORTS-1:0] port_tx_tap,
    output logic [NUM_PORTS-1:0] port_rx_vld,
    output logic                 port_rxd,
    input  logic                 d_tx_valid,
    input  logic [1:0]           d_tx_bits,
    output logic                 d_tx_taken,
    output logic [7:0]           rx_b1,
    output logic [7:0]           rx_b2,
    output logic [1:0]           rx_d,
    output logic                 rx_frame_vld
);

    logic [POS_W-1:0]  pos;
    logic              in_frame;
    logic              slot_act;
    logic              last_slot;
    slot_info_t        slot_info;
    logic [CODE_W-1:0] code;
    logic              d_cmt;
    logic [1:0]        d_hold;

    frm_timer #(.FRAME_LEN(FRAME_LEN)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .sync_in   (l1_sync),
        .fmt10_in  (fmt10_sel),
        .pos       (pos),
        .in_frame  (in_frame),
        .slot_act  (slot_act),
        .last_slot (last_slot),
        .slot_info (slot_info)
    );

    frm_route_tab #(.CODE_W(CODE_W)) u_route (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (rt_wr_en),
        .wr_slot (rt_wr_slot),
        .wr_code (rt_wr_code),
        .commit  (l1_sync),
        .rd_slot (pos[SLOT_W-1:0]),
        .rd_code (code)
    );

    frm_dchan u_dchan (
        .clk     (clk),
        .rst     (rst),
        .sync_in (l1_sync),
        .gnt     (l1_gnt),
        .pend    (d_tx_valid),
        .bits_in (d_tx_bits),
        .at_d2   (slot_info.kind == SK_D2),
        .cmt     (d_cmt),
        .hold    (d_hold),
        .req     (l1_req),
        .taken   (d_tx_taken)
    );

    frm_rx_capture #(.NUM_PORTS(NUM_PORTS), .CODE_W(CODE_W)) u_rx (
        .clk          (clk),
        .rst          (rst),
        .rxd          (l1_rxd),
        .slot_act     (slot_act),
        .last_slot    (last_slot),
        .slot_info    (slot_info),
        .code         (code),
        .port_rx_vld  (port_rx_vld),
        .port_rxd     (port_rxd),
        .rx_b1        (rx_b1),
        .rx_b2        (rx_b2),
        .rx_d         (rx_d),
        .rx_frame_vld (rx_frame_vld)
    );

    // Transmit selection: D positions belong to the contention engine,
    // every other active position follows the live routing entry.
    always_comb begin
        l1_txd      = 1'b1;
        l1_strobe   = 1'b0;
        port_tx_tap = '0;
        if (slot_act) begin
            l1_strobe = (code == CODE_W'(RC_STRB));
            for (int k = 0; k < NUM_PORTS; k++) begin
                if (code == CODE_W'(RC_PORT0 + k)) begin
                    port_tx_tap[k] = 1'b1;
                end
            end
            if (is_dslot(slot_info)) begin
                l1_txd = d_cmt ? d_hold[slot_info.kind == SK_D1] : 1'b1;
            end else begin
                for (int k = 0; k < NUM_PORTS; k++) begin
                    if (port_tx_tap[k]) begin
                        l1_txd = port_txd[k];
                    end
                end
            end
        end
    end

    // R8: strobe and port ownership never share a position
    a_r8_strobe_excl: assert property (@(posedge clk) disable iff (rst)
        l1_strobe |-> (port_tx_tap == '0));

    // R7: nothing but ones on the line outside a frame
    a_r7_idle_between_frames: assert property (@(posedge clk) disable iff (rst)
        !in_frame |-> (l1_txd && !l1_strobe && port_tx_tap == '0));

endmodule

// File: tb/test_isdn_idl_frm.sv
module test_isdn_idl_frm;

    logic       clk = 1'b0;
    logic       rst;
    logic       l1_sync, l1_rxd, l1_gnt, fmt10_sel;
    logic       rt_wr_en;
    logic [4:0] rt_wr_slot;
    logic [2:0] rt_wr_code;
    logic [3:0] port_txd;
    logic       d_tx_valid;
    logic [1:0] d_tx_bits;
    logic       l1_txd, l1_req, l1_strobe, port_rxd, d_tx_taken, rx_frame_vld;
    logic [3:0] port_tx_tap, port_rx_vld;
    logic [7:0] rx_b1, rx_b2;
    logic [1:0] rx_d;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [2:0] shd_m [20];
    logic [2:0] act_m [20];

    always #4 clk = ~clk;

    isdn_idl_frm i_isdn_idl_frm (
        .clk(clk), .rst(rst), .l1_sync(l1_sync), .l1_rxd(l1_rxd), .l1_txd(l1_txd),
        .l1_gnt(l1_gnt), .l1_req(l1_req), .l1_strobe(l1_strobe), .fmt10_sel(fmt10_sel),
        .rt_wr_en(rt_wr_en), .rt_wr_slot(rt_wr_slot), .rt_wr_code(rt_wr_code),
        .port_txd(port_txd), .port_tx_tap(port_tx_tap), .port_rx_vld(port_rx_vld),
        .port_rxd(port_rxd), .d_tx_valid(d_tx_valid), .d_tx_bits(d_tx_bits),
        .d_tx_taken(d_tx_taken), .rx_b1(rx_b1), .rx_b2(rx_b2), .rx_d(rx_d),
        .rx_frame_vld(rx_frame_vld)
    );

    typedef struct packed {
        logic        fmt10;
        logic        gnt;
        logic        dval;
        logic [1:0]  dbits;
        logic [3:0]  ptx;
        logic [19:0] rxpat;
    } vec_t;

    localparam int NV = 6;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b1, 1'b1, 2'b01, 4'b1010, 20'hA5C3F},
        '{1'b0, 1'b0, 1'b1, 2'b10, 4'b0101, 20'h31E69},
        '{1'b0, 1'b1, 1'b1, 2'b10, 4'b1100, 20'h0F0F0},
        '{1'b1, 1'b1, 1'b0, 2'b11, 4'b0011, 20'h12345},
        '{1'b1, 1'b0, 1'b0, 2'b00, 4'b1111, 20'hEDCBA},
        '{1'b0, 1'b1, 1'b1, 2'b00, 4'b0110, 20'h5A5A5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Channel layout per R3 / R4: 1 B1, 2 B2, 3 D1, 4 D2, 0 other.
    function automatic int kind_of(input int p, input bit f10);
        if (p < 8) return 1;
        if (f10) begin
            if (p == 8) return 3;
            if (p >= 10 && p < 18) return 2;
            if (p == 18) return 4;
            return 0;
        end
        if (p < 16) return 2;
        if (p == 16) return 3;
        if (p == 17) return 4;
        return 0;
    endfunction

    task automatic wr_route(input int slot, input logic [2:0] c);
        @(posedge clk); #1;
        rt_wr_en = 1'b1; rt_wr_slot = 5'(slot); rt_wr_code = c;
        shd_m[slot] = c;
        @(posedge clk); #1;
        rt_wr_en = 1'b0;
    endtask

    task automatic run_frame(input vec_t v, input bit sync_wr, input bit mid_wr);
        bit         cmt;
        int         d2;
        logic [7:0] eb1, eb2;
        logic [1:0] ed;
        @(posedge clk); #1;
        l1_sync = 1'b1; l1_gnt = v.gnt; d_tx_valid = v.dval; d_tx_bits = v.dbits;
        fmt10_sel = v.fmt10; port_txd = v.ptx;
        if (sync_wr) begin
            rt_wr_en = 1'b1; rt_wr_slot = 5'd4; rt_wr_code = 3'd1;
            shd_m[4] = 3'd1;
        end
        for (int i = 0; i < 20; i++) act_m[i] = shd_m[i];
        cmt = v.gnt && v.dval;
        d2  = v.fmt10 ? 18 : 17;
        eb1 = '0; eb2 = '0; ed = '0;
        @(posedge clk); #1;
        l1_sync = 1'b0; rt_wr_en = 1'b0;
        l1_gnt = ~v.gnt;  // R11: grant after sync must be ignored
        for (int p = 0; p <= 21; p++) begin
            if (p > 0 && p <= 20) begin
                logic [2:0] cp;
                logic [3:0] ev;
                cp = act_m[p-1];
                ev = (cp >= 3'd2) ? 4'(1 << (cp - 3'd2)) : 4'd0;
                check(ev != 0 ? "R6 port_rx_vld" : "R7 port_rx_vld", 32'(port_rx_vld), 32'(ev));
                if (ev != 0) check("R6 port_rxd", 32'(port_rxd), 32'(v.rxpat[p-1]));
            end
            if (p == 0) check("R10 l1_req", 32'(l1_req), 32'(v.dval));
            if (p == d2 + 1) begin
                check(cmt ? "R11 d_tx_taken" : "R12 d_tx_taken", 32'(d_tx_taken), 32'(cmt));
                if (cmt) d_tx_valid = 1'b0;
            end
            if (p == d2 + 2) begin
                if (cmt) check("R10 l1_req dropped", 32'(l1_req), 32'd0);
                else     check("R12 l1_req held", 32'(l1_req), 32'(v.dval));
            end
            if (p == 5 && mid_wr) begin
                rt_wr_en = 1'b1; rt_wr_slot = 5'd7; rt_wr_code = 3'd1;
                shd_m[7] = 3'd1;
            end
            if (p == 6) rt_wr_en = 1'b0;
            if (p < 20) begin
                int         k;
                logic [2:0] c;
                logic       et;
                logic [3:0] etap;
                k = kind_of(p, v.fmt10);
                c = act_m[p];
                etap = (c >= 3'd2) ? 4'(1 << (c - 3'd2)) : 4'd0;
                if (k == 3)      et = cmt ? v.dbits[1] : 1'b1;
                else if (k == 4) et = cmt ? v.dbits[0] : 1'b1;
                else if (c >= 3'd2) et = v.ptx[c - 3'd2];
                else             et = 1'b1;
                check(k >= 3 ? (cmt ? "R11 D slot" : "R12 D slot")
                             : (v.fmt10 ? "R3 l1_txd" : "R4 l1_txd"), 32'(l1_txd), 32'(et));
                check("R8 l1_strobe", 32'(l1_strobe), 32'(c == 3'd1));
                check("R6 port_tx_tap", 32'(port_tx_tap), 32'(etap));
                l1_rxd = v.rxpat[p];
                if (k == 1) eb1[7 - p] = v.rxpat[p];
                if (k == 2) eb2[7 - (v.fmt10 ? p - 10 : p - 8)] = v.rxpat[p];
                if (k == 3) ed[1] = v.rxpat[p];
                if (k == 4) ed[0] = v.rxpat[p];
            end else if (p == 20) begin
                check("R5 rx_frame_vld", 32'(rx_frame_vld), 32'd1);
                check(v.fmt10 ? "R3 rx_b1" : "R4 rx_b1", 32'(rx_b1), 32'(eb1));
                check(v.fmt10 ? "R3 rx_b2" : "R4 rx_b2", 32'(rx_b2), 32'(eb2));
                check("R5 rx_d", 32'(rx_d), 32'(ed));
                check("R7 txd past window", 32'(l1_txd), 32'd1);
            end else begin
                check("R5 rx_frame_vld pulse", 32'(rx_frame_vld), 32'd0);
            end
            @(posedge clk); #1;
        end
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; l1_sync = 1'b0; l1_rxd = 1'b1; l1_gnt = 1'b0; fmt10_sel = 1'b0;
        rt_wr_en = 1'b0; rt_wr_slot = '0; rt_wr_code = '0; port_txd = '0;
        d_tx_valid = 1'b0; d_tx_bits = '0;
        for (int i = 0; i < 20; i++) begin shd_m[i] = 3'd0; act_m[i] = 3'd0; end
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        check("R1 l1_txd", 32'(l1_txd), 32'd1);
        check("R1 l1_req", 32'(l1_req), 32'd0);
        check("R1 l1_strobe", 32'(l1_strobe), 32'd0);
        check("R1 d_tx_taken", 32'(d_tx_taken), 32'd0);
        check("R1 rx_frame_vld", 32'(rx_frame_vld), 32'd0);
        check("R1 port_rx_vld", 32'(port_rx_vld), 32'd0);
        check("R1 port_tx_tap", 32'(port_tx_tap), 32'd0);

        for (int i = 0; i < 20; i++) wr_route(i, 3'(i % 6));
        // R9: writes before the first sync must not be live yet
        check("R9 not live before sync", 32'(port_tx_tap), 32'd0);

        for (int i = 0; i < NV; i++) run_frame(VECS[i], 1'b0, 1'b0);

        // R9: write in the sync cycle joins that frame; mid-frame write waits
        run_frame(VECS[0], 1'b1, 1'b1);
        run_frame(VECS[3], 1'b0, 1'b0);
        // R2: a frame straight after a short gap realigns to position 0
        run_frame(VECS[2], 1'b0, 1'b0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule